// File: doc/BRIEF.md
# Paged Microcode Register Window

This block is the word-addressed register front end of a microcoded vertex coprocessor. A 32-bit single-cycle bus reaches three areas through it: twelve control and status words, a directly mapped view of the 128-entry general register file, and a 512-word view into a 2048-word microcode store. A page register chooses which quarter of the store the view shows. The execution engine and the DMA engine sit outside the block. The engine reads microcode and general registers through dedicated ports, writes results back into the register file, and reports the end of a run together with its status counters.

Software loads the microcode page by page and seeds the general registers. It programs the mesh base and the last horizontal and vertical indices, then sets the start bit in the control word. From then until the engine reports completion, the block is busy. The busy flag reads back in bit 0 of the control word, and bus writes to the register file and to microcode are dropped. Accesses to holes in the map read zero, have no effect, and raise a sticky error flag.

Top module: `vcop_regwin`

## Requirements
- R1: After a synchronous active-low reset, every control and status word, every general register and every microcode word reads zero, and `bus_err`, `run_busy` and `run_start` are low.
- R2: Word offsets 1 to 11 are read/write storage that reads back the last value written. Offset 1 holds the mesh base, offset 2 the last horizontal index, offset 3 the last vertical index, offset 4 the code page, offsets 5 to 9 the vertex count, collision count, stray-write count, last DMA address and program counter, and offsets 10 and 11 the register-file base and code base. Offsets 1 to 3 drive `cfg_mesh_base`, `cfg_hlast` and `cfg_vlast`.
- R3: The word offset is the byte address shifted right by two, so bits 1:0 of `bus_addr` have no effect on which word is reached.
- R4: Word offsets 0x100 to 0x17F read and write general register (offset − 0x100).
- R5: Word offsets 0x200 to 0x3FF reach microcode word 512 × page + (offset − 0x200). The engine reads word `eng_code_addr` of the full store on `eng_code_data`.
- R6: A write to offset 0 with bit 0 set while idle raises `run_start` for exactly the following cycle and sets busy. Offset 0 reads 1 while busy and 0 when idle. A write with bit 0 clear starts nothing.
- R7: While busy, bus writes to the general registers and to microcode are ignored, and a further start write produces no new `run_start` pulse.
- R8: `eng_done` while busy clears busy in the next cycle and loads offsets 5 to 9 from the engine status inputs. In the same cycle it takes priority over a bus write to those words. `eng_done` while idle has no effect.
- R9: `eng_gpr_we` writes `eng_gpr_wdata` into general register `eng_gpr_waddr` whether or not the block is busy. `eng_gpr_raddr` reads a register on `eng_gpr_rdata`.
- R10: An access to an unmapped offset (12 to 0xFF, 0x180 to 0x1FF) reads zero and changes no stored word. It sets `bus_err`, which then stays set until reset.
- R11: The code page keeps only its low two bits (page 0 to 3). Writing 7 reads back 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, same cycle |
| bus_err | output | 1 | Sticky unmapped-access flag |
| run_start | output | 1 | One-cycle launch pulse to the engine |
| run_busy | output | 1 | Run in progress |
| eng_done | input | 1 | Engine finished the run |
| eng_vertices | input | 32 | Vertex count reported at completion |
| eng_collisions | input | 32 | Collision count reported at completion |
| eng_strays | input | 32 | Stray-write count reported at completion |
| eng_last_dma | input | 32 | Last DMA address reported at completion |
| eng_pc | input | 32 | Program counter reported at completion |
| cfg_mesh_base | output | 32 | Mesh base address |
| cfg_hlast | output | 32 | Last horizontal index |
| cfg_vlast | output | 32 | Last vertical index |
| eng_code_addr | input | 11 | Engine microcode read index |
| eng_code_data | output | 32 | Engine microcode read data |
| eng_gpr_raddr | input | 7 | Engine register-file read index |
| eng_gpr_rdata | output | 32 | Engine register-file read data |
| eng_gpr_we | input | 1 | Engine register-file write enable |
| eng_gpr_waddr | input | 7 | Engine register-file write index |
| eng_gpr_wdata | input | 32 | Engine register-file write data |

## Verification
Completion from the engine and a bus access can land on the same clock edge. The bench drives `eng_done` with status values and, in that same cycle, a bus write of a different value to the vertex-count word. It then reads offsets 5 to 9 and expects the engine's values, and reads offset 0 and expects idle. The second overlap is a bus write to microcode or the register file while busy, alongside an engine write-back in the next cycle. Here the bus write must leave the old word in place and the engine write must land.

// File: rtl/vcop_regwin_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the paged microcode register window.
// Assumes the window bases stay aligned to their own sizes.
package vcop_regwin_pkg;

    localparam int CSR_N     = 12;
    localparam int GPR_BASE  = 'h100;
    localparam int CODE_BASE = 'h200;

    typedef enum logic [3:0] {
        CSR_CTL   = 4'd0,
        CSR_MESH  = 4'd1,
        CSR_HLAST = 4'd2,
        CSR_VLAST = 4'd3,
        CSR_PAGE  = 4'd4,
        CSR_VERT  = 4'd5,
        CSR_COLL  = 4'd6,
        CSR_STRAY = 4'd7,
        CSR_LDMA  = 4'd8,
        CSR_PC    = 4'd9,
        CSR_DBASE = 4'd10,
        CSR_CBASE = 4'd11
    } csr_idx_e;

    typedef enum logic [1:0] {
        WIN_CSR,
        WIN_GPR,
        WIN_CODE,
        WIN_NONE
    } win_e;

endpackage

// File: rtl/vcop_csr.sv
`timescale 1ns/1ps
// Control and status words of the window.
// Holds the run flag, the launch pulse, configuration and the engine's
// completion status. Assumes wr_idx/rd_idx are only meaningful when the
// decoder selected the control area (wr_en gates writes).
module vcop_csr
    import vcop_regwin_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_vertices,
    input  logic [DATA_W-1:0] eng_collisions,
    input  logic [DATA_W-1:0] eng_strays,
    input  logic [DATA_W-1:0] eng_last_dma,
    input  logic [DATA_W-1:0] eng_pc,
    output logic              busy,
    output logic              run_start,
    output logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] mesh_base,
    output logic [DATA_W-1:0] hlast,
    output logic [DATA_W-1:0] vlast
);

    logic [DATA_W-1:0] csr_q [1:CSR_N-1];

    // Run flag, launch pulse and stored words; engine status wins over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            run_start <= 1'b0;
            for (int i = 1; i < CSR_N; i++) csr_q[i] <= '0;
        end else begin
            run_start <= 1'b0;
            if (wr_en && wr_idx == CSR_CTL && wr_data[0] && !busy) begin
                busy      <= 1'b1;
                run_start <= 1'b1;
            end
            for (int i = 1; i < CSR_N; i++) begin
                if (wr_en && wr_idx == 4'(i)) begin
                    if (i == int'(CSR_PAGE))
                        csr_q[i] <= DATA_W'(wr_data[PAGE_W-1:0]);
                    else
                        csr_q[i] <= wr_data;
                end
            end
            if (eng_done && busy) begin
                busy          <= 1'b0;
                csr_q[CSR_VERT]  <= eng_vertices;
                csr_q[CSR_COLL]  <= eng_collisions;
                csr_q[CSR_STRAY] <= eng_strays;
                csr_q[CSR_LDMA]  <= eng_last_dma;
                csr_q[CSR_PC]    <= eng_pc;
            end
        end
    end

    // Read mux: offset 0 shows the run flag, the rest show stored words.
    always_comb begin
        rd_data = '0;
        if (rd_idx == CSR_CTL) rd_data = DATA_W'(busy);
        for (int i = 1; i < CSR_N; i++)
            if (rd_idx == 4'(i)) rd_data = csr_q[i];
    end

    assign page      = csr_q[CSR_PAGE][PAGE_W-1:0];
    assign mesh_base = csr_q[CSR_MESH];
    assign hlast     = csr_q[CSR_HLAST];
    assign vlast     = csr_q[CSR_VLAST];

    // R6: the launch pulse lasts one cycle
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> !run_start);
    // R6: a launch pulse is always accompanied by busy
    p_pulse_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> busy);
    // R8: busy holds until the engine reports completion
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> busy);
    // R8: completion while busy returns to idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

endmodule

// File: rtl/vcop_gpr.sv
`timescale 1ns/1ps
// General register file with one bus write port, one engine write port
// and two combinational read ports. The engine write wins on a clash.
// Assumes the caller already gated the bus write with the run flag.
module vcop_gpr #(
    parameter int N      = 128,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_widx,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_widx,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic [AW-1:0]     bus_ridx,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [AW-1:0]     eng_ridx,
    output logic [DATA_W-1:0] eng_rdata
);

    logic [DATA_W-1:0] regs_q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // One register: reset, engine write-back first, then bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (eng_we && eng_widx == AW'(g))
                regs_q[g] <= eng_wdata;
            else if (bus_we && bus_widx == AW'(g))
                regs_q[g] <= bus_wdata;
        end
    end

    assign bus_rdata = regs_q[bus_ridx];
    assign eng_rdata = regs_q[eng_ridx];

endmodule

// File: rtl/vcop_code.sv
`timescale 1ns/1ps
// Microcode store: one bus write port, a bus read port and an engine read
// port, both combinational. Reset clears every word.
// Assumes the caller formed the full index from page and window offset.
module vcop_code #(
    parameter int N      = 2048,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     bus_ridx,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [AW-1:0]     eng_ridx,
    output logic [DATA_W-1:0] eng_rdata
);

    logic [DATA_W-1:0] mem_q [N];

    // Store update: clear on reset, otherwise accept the gated bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign bus_rdata = mem_q[bus_ridx];
    assign eng_rdata = mem_q[eng_ridx];

endmodule

// File: rtl/vcop_regwin.sv
`timescale 1ns/1ps
// Top of the paged microcode register window. Decodes the word offset into
// the control area, the register-file window and the paged microcode window,
// gates storage writes with the run flag and keeps a sticky error for holes.
// Assumes one access per cycle and whole 32-bit words only.
module vcop_regwin
    import vcop_regwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int GPR_N  = 128,
    parameter int CODE_N = 2048,
    parameter int WIN_N  = 512,
    localparam int OFS_W   = ADDR_W - 2,
    localparam int GPR_AW  = $clog2(GPR_N),
    localparam int CODE_AW = $clog2(CODE_N),
    localparam int WIN_AW  = $clog2(WIN_N),
    localparam int PAGE_W  = CODE_AW - WIN_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               run_start,
    output logic               run_busy,
    input  logic               eng_done,
    input  logic [DATA_W-1:0]  eng_vertices,
    input  logic [DATA_W-1:0]  eng_collisions,
    input  logic [DATA_W-1:0]  eng_strays,
    input  logic [DATA_W-1:0]  eng_last_dma,
    input  logic [DATA_W-1:0]  eng_pc,
    output logic [DATA_W-1:0]  cfg_mesh_base,
    output logic [DATA_W-1:0]  cfg_hlast,
    output logic [DATA_W-1:0]  cfg_vlast,
    input  logic [CODE_AW-1:0] eng_code_addr,
    output logic [DATA_W-1:0]  eng_code_data,
    input  logic [GPR_AW-1:0]  eng_gpr_raddr,
    output logic [DATA_W-1:0]  eng_gpr_rdata,
    input  logic               eng_gpr_we,
    input  logic [GPR_AW-1:0]  eng_gpr_waddr,
    input  logic [DATA_W-1:0]  eng_gpr_wdata
);

    localparam logic [OFS_W-1:0] CSR_HI  = OFS_W'(CSR_N - 1);
    localparam logic [OFS_W-1:0] GPR_LO  = OFS_W'(GPR_BASE);
    localparam logic [OFS_W-1:0] GPR_HI  = OFS_W'(GPR_BASE + GPR_N - 1);
    localparam logic [OFS_W-1:0] CODE_LO = OFS_W'(CODE_BASE);
    localparam logic [OFS_W-1:0] CODE_HI = OFS_W'(CODE_BASE + WIN_N - 1);

    logic [OFS_W-1:0]   wofs;
    logic [1:0]         unused_lsb;
    win_e               win;
    logic [PAGE_W-1:0]  page;
    logic [CODE_AW-1:0] code_idx;
    logic [GPR_AW-1:0]  gpr_idx;
    logic               wr_access;
    logic               csr_we, gpr_we, code_we;
    logic [DATA_W-1:0]  csr_rdata, gpr_rdata, code_rdata;
    logic               err_q;

    assign wofs       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = bus_addr[1:0];

    // Window decode from the word offset.
    always_comb begin
        if (wofs <= CSR_HI)                         win = WIN_CSR;
        else if (wofs >= GPR_LO && wofs <= GPR_HI)  win = WIN_GPR;
        else if (wofs >= CODE_LO && wofs <= CODE_HI) win = WIN_CODE;
        else                                        win = WIN_NONE;
    end

    assign gpr_idx   = wofs[GPR_AW-1:0];
    assign code_idx  = {page, wofs[WIN_AW-1:0]};
    assign wr_access = bus_sel && bus_we;
    assign csr_we    = wr_access && win == WIN_CSR;
    assign gpr_we    = wr_access && win == WIN_GPR && !run_busy;
    assign code_we   = wr_access && win == WIN_CODE && !run_busy;

    vcop_csr #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_csr (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (csr_we),
        .wr_idx         (wofs[3:0]),
        .wr_data        (bus_wdata),
        .rd_idx         (wofs[3:0]),
        .rd_data        (csr_rdata),
        .eng_done       (eng_done),
        .eng_vertices   (eng_vertices),
        .eng_collisions (eng_collisions),
        .eng_strays     (eng_strays),
        .eng_last_dma   (eng_last_dma),
        .eng_pc         (eng_pc),
        .busy           (run_busy),
        .run_start      (run_start),
        .page           (page),
        .mesh_base      (cfg_mesh_base),
        .hlast          (cfg_hlast),
        .vlast          (cfg_vlast)
    );

    vcop_gpr #(.N(GPR_N), .DATA_W(DATA_W)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (gpr_we),
        .bus_widx  (gpr_idx),
        .bus_wdata (bus_wdata),
        .eng_we    (eng_gpr_we),
        .eng_widx  (eng_gpr_waddr),
        .eng_wdata (eng_gpr_wdata),
        .bus_ridx  (gpr_idx),
        .bus_rdata (gpr_rdata),
        .eng_ridx  (eng_gpr_raddr),
        .eng_rdata (eng_gpr_rdata)
    );

    vcop_code #(.N(CODE_N), .DATA_W(DATA_W)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (code_we),
        .wr_idx    (code_idx),
        .wr_data   (bus_wdata),
        .bus_ridx  (code_idx),
        .bus_rdata (code_rdata),
        .eng_ridx  (eng_code_addr),
        .eng_rdata (eng_code_data)
    );

    // Read data select; holes read zero.
    always_comb begin
        unique case (win)
            WIN_CSR:  bus_rdata = csr_rdata;
            WIN_GPR:  bus_rdata = gpr_rdata;
            WIN_CODE: bus_rdata = code_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    // Sticky error on any access that falls in a hole.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (bus_sel && win == WIN_NONE)
            err_q <= 1'b1;
    end

    assign bus_err = err_q;

    // R10: the error flag never clears without reset
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: tb/vcop_regwin_test.sv
`timescale 1ns/1ps
module vcop_regwin_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, run_start, run_busy;
    logic        eng_done = 1'b0;
    logic [31:0] eng_vertices = '0, eng_collisions = '0, eng_strays = '0;
    logic [31:0] eng_last_dma = '0, eng_pc = '0;
    logic [31:0] cfg_mesh_base, cfg_hlast, cfg_vlast;
    logic [10:0] eng_code_addr = '0;
    logic [31:0] eng_code_data;
    logic [6:0]  eng_gpr_raddr = '0;
    logic [31:0] eng_gpr_rdata;
    logic        eng_gpr_we = 1'b0;
    logic [6:0]  eng_gpr_waddr = '0;
    logic [31:0] eng_gpr_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vcop_regwin uut (.*);

    // {requirement, is_write, byte address, data or expected read}
    localparam int NV = 28;
    localparam logic [48:0] VEC [NV] = '{
        {4'd2,  1'b1, 12'h004, 32'h12345678},  // R2 mesh base
        {4'd2,  1'b0, 12'h004, 32'h12345678},
        {4'd2,  1'b1, 12'h008, 32'h0000003F},  // R2 hlast
        {4'd2,  1'b0, 12'h008, 32'h0000003F},
        {4'd2,  1'b1, 12'h00C, 32'h0000002F},  // R2 vlast
        {4'd2,  1'b0, 12'h00C, 32'h0000002F},
        {4'd2,  1'b1, 12'h028, 32'h0000BEAD},  // R2 register-file base
        {4'd2,  1'b0, 12'h028, 32'h0000BEAD},
        {4'd11, 1'b1, 12'h010, 32'h00000007},  // R11 page masked
        {4'd11, 1'b0, 12'h010, 32'h00000003},
        {4'd5,  1'b1, 12'h800, 32'h0000DEAD},  // R5 page 3 -> word 1536
        {4'd5,  1'b0, 12'h800, 32'h0000DEAD},
        {4'd5,  1'b1, 12'hFFC, 32'h00C0FFEE},  // R5 word 2047
        {4'd5,  1'b0, 12'hFFC, 32'h00C0FFEE},
        {4'd5,  1'b1, 12'h010, 32'h00000000},  // R5 page 0
        {4'd5,  1'b0, 12'h800, 32'h00000000},
        {4'd3,  1'b1, 12'h803, 32'h0000BEEF},  // R3 low bits ignored
        {4'd3,  1'b0, 12'h800, 32'h0000BEEF},
        {4'd5,  1'b1, 12'h010, 32'h00000003},  // R5 back to page 3
        {4'd5,  1'b0, 12'h800, 32'h0000DEAD},
        {4'd4,  1'b1, 12'h400, 32'h00000011},  // R4 register 0
        {4'd4,  1'b0, 12'h400, 32'h00000011},
        {4'd4,  1'b1, 12'h5FE, 32'h00000077},  // R4 register 127
        {4'd4,  1'b0, 12'h5FC, 32'h00000077},
        {4'd10, 1'b1, 12'h030, 32'h00000005},  // R10 hole write
        {4'd10, 1'b0, 12'h030, 32'h00000000},
        {4'd10, 1'b0, 12'h600, 32'h00000000},  // R10 hole read
        {4'd10, 1'b0, 12'h5FC, 32'h00000077}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        bus_read(12'h000, rd); check("R1 control", rd, 32'h0);
        bus_read(12'h004, rd); check("R1 mesh base", rd, 32'h0);
        bus_read(12'h014, rd); check("R1 vertex count", rd, 32'h0);
        bus_read(12'h400, rd); check("R1 register 0", rd, 32'h0);
        bus_read(12'h800, rd); check("R1 microcode 0", rd, 32'h0);
        check("R1 error flag", 32'(bus_err), 32'h0);
        check("R1 launch pulse", 32'(run_start), 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44])
                bus_write(VEC[i][43:32], VEC[i][31:0]);
            else begin
                bus_read(VEC[i][43:32], rd);
                check($sformatf("R%0d table entry %0d", VEC[i][48:45], i), rd, VEC[i][31:0]);
            end
        end
        @(negedge clk) bus_sel = 1'b0;
        check("R10 error set and sticky", 32'(bus_err), 32'h1);
        check("R2 cfg mesh base", cfg_mesh_base, 32'h12345678);
        check("R2 cfg hlast", cfg_hlast, 32'h3F);
        check("R2 cfg vlast", cfg_vlast, 32'h2F);

        // R5 / R9 engine read ports
        eng_code_addr = 11'd2047; eng_gpr_raddr = 7'd127;
        #1;
        check("R5 engine code port", eng_code_data, 32'h00C0FFEE);
        check("R9 engine register port", eng_gpr_rdata, 32'h77);
        eng_code_addr = 11'd0;
        #1 check("R5 engine code word 0", eng_code_data, 32'h0000BEEF);

        // R6 start with bit 0 clear does nothing
        bus_write(12'h000, 32'hFFFF_FFFE);
        check("R6 no launch on bit0 clear", 32'(run_start), 32'h0);
        bus_read(12'h000, rd); check("R6 still idle", rd, 32'h0);

        // R6 launch
        bus_write(12'h000, 32'h1);
        check("R6 launch pulse", 32'(run_start), 32'h1);
        bus_read(12'h000, rd); check("R6 busy reads 1", rd, 32'h1);
        check("R6 pulse one cycle", 32'(run_start), 32'h0);

        // R7 writes ignored while busy
        bus_write(12'h414, 32'h99);
        bus_read(12'h414, rd); check("R7 register write ignored", rd, 32'h0);
        bus_write(12'hFFC, 32'h5555);
        bus_read(12'hFFC, rd); check("R7 microcode write ignored", rd, 32'h00C0FFEE);
        bus_write(12'h000, 32'h1);
        check("R7 no second launch", 32'(run_start), 32'h0);

        // R9 engine write-back while busy
        @(negedge clk);
        eng_gpr_we = 1'b1; eng_gpr_waddr = 7'd9; eng_gpr_wdata = 32'hABC;
        @(negedge clk) eng_gpr_we = 1'b0;
        bus_read(12'h424, rd); check("R9 engine write lands", rd, 32'hABC);

        // R8 completion with a same-cycle bus write to the vertex count
        @(negedge clk);
        eng_done = 1'b1; eng_vertices = 32'h600; eng_collisions = 32'h3;
        eng_strays = 32'h2; eng_last_dma = 32'h4000_0104; eng_pc = 32'h2A;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h014; bus_wdata = 32'h1;
        @(negedge clk);
        eng_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        bus_read(12'h000, rd); check("R8 idle after done", rd, 32'h0);
        bus_read(12'h014, rd); check("R8 engine beats bus on vertices", rd, 32'h600);
        bus_read(12'h018, rd); check("R8 collisions", rd, 32'h3);
        bus_read(12'h01C, rd); check("R8 strays", rd, 32'h2);
        bus_read(12'h020, rd); check("R8 last dma", rd, 32'h4000_0104);
        bus_read(12'h024, rd); check("R8 pc", rd, 32'h2A);

        // R8 done while idle is ignored
        @(negedge clk);
        eng_done = 1'b1; eng_vertices = 32'h7;
        @(negedge clk) eng_done = 1'b0;
        bus_read(12'h014, rd); check("R8 idle done ignored", rd, 32'h600);

        // R7 writes accepted again once idle
        bus_write(12'h414, 32'h99);
        bus_read(12'h414, rd); check("R7 write accepted when idle", rd, 32'h99);

        // R1 reset clears everything written
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 error cleared", 32'(bus_err), 32'h0);
        check("R1 cfg mesh cleared", cfg_mesh_base, 32'h0);
        bus_read(12'h010, rd); check("R1 page cleared", rd, 32'h0);
        bus_read(12'h400, rd); check("R1 register cleared", rd, 32'h0);
        bus_write(12'h010, 32'h3);
        bus_read(12'h800, rd); check("R1 microcode cleared", rd, 32'h0);
        bus_read(12'h014, rd); check("R1 status cleared", rd, 32'h0);
        @(negedge clk) bus_sel = 1'b0;

        summary();
    end

endmodule